// File: doc/BRIEF.md
# ATM Cell Payload CRC Engine

This block sits in a byte-wide cell datapath and handles two cyclic redundancy checks on 48-byte cell payloads. The first is a short 10-bit check that belongs to a single cell. The second is a 32-bit check that covers a whole packet spread over several cells. In transmit mode the block writes the computed values into the payload as the bytes stream past. In receive mode it leaves the bytes untouched, compares the computed values with the ones carried in the cell, and raises a one-cycle error flag at the end of the cell or packet when they disagree.

The stream has no gaps inside the protocol. A cell is a run of accepted bytes (`in_valid` high) that begins with `in_soc`. The per-cell flags `in_last` (this cell closes its packet) and `in_c10` (this cell carries the 10-bit check) are sampled together with `in_soc`. Idle cycles may fall between any two bytes. Back-to-back cells and packets need no idle cycle between them. Every byte reappears on the output exactly one clock later.

Top module: `atm_crc_engine`

## Requirements
- R1: After reset `out_valid`, `out_soc`, `out_eoc`, `out_eop`, `c10_err` and `c32_err` are all low.
- R2: Each accepted byte appears on `out_data` one cycle later with `out_valid` high; `out_soc`, `out_eoc` (byte 47) and `out_eop` (byte 47 of a cell flagged last) are aligned with it; bytes 0 to 43 are never changed.
- R3: The 10-bit check is the remainder of the first 374 payload bits times x^10 divided by x^10+x^9+x^5+x^4+x+1, with a start value of zero. In transmit mode, for a non-last cell with `in_c10` set, bits 1:0 of byte 46 become check bits 9:8 and byte 47 becomes check bits 7:0.
- R4: In transmit mode a non-last cell with `in_c10` clear leaves the block unchanged.
- R5: In receive mode, for a non-last cell with `in_c10` set, `c10_err` pulses with `out_eoc` when the received field ({byte46[1:0], byte47}) differs from the computed check. It stays low otherwise.
- R6: The 32-bit check uses polynomial 0x04C11DB7, MSB-first bit order and an all-ones start. It covers every byte of the packet except the last four bytes of its final cell, and it is complemented at the end. In transmit mode it replaces bytes 44 to 47 of the last cell, most significant byte first.
- R7: In receive mode `c32_err` pulses with `out_eop` when bytes 44 to 47 of the last cell differ from the computed 32-bit check.
- R8: The 32-bit check restarts with the first cell after a last cell, so consecutive packets are independent even with no idle cycle between them.
- R9: In a cell flagged last, `in_c10` has no effect: there is no 10-bit insertion, no 10-bit check, and bytes 46 and 47 carry the 32-bit check.
- R10: In receive mode every byte passes unchanged; in transmit mode both error flags stay low.
- R11: Idle input cycles produce no output byte and do not disturb either check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mode | input | 1 | 1 = transmit (insert), 0 = receive (check) |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Payload byte |
| in_soc | input | 1 | First byte of a cell |
| in_last | input | 1 | Cell closes its packet; sampled with `in_soc` |
| in_c10 | input | 1 | Cell carries the 10-bit check; sampled with `in_soc` |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Payload byte after insertion |
| out_soc | output | 1 | First byte of a cell |
| out_eoc | output | 1 | Last byte of a cell |
| out_eop | output | 1 | Last byte of a packet |
| c10_err | output | 1 | 10-bit check mismatch, with `out_eoc` |
| c32_err | output | 1 | 32-bit check mismatch, with `out_eop` |

## Verification
The assertions assume well-formed framing. Every cell is exactly 48 accepted bytes, `in_soc` appears only on the first of them, and `tx_mode` changes only while no cell is in flight. The bench respects this by driving only whole cells through one task and by switching mode only between runs, after the last output byte has drained. Idle cycles are placed only between bytes, never by cutting a cell short.

// File: rtl/atm_crc_pkg.sv
package atm_crc_pkg;

  localparam logic [9:0]  C10_POLY = 10'h233;
  localparam logic [31:0] C32_POLY = 32'h04C11DB7;

  // Advance the 10-bit check by the top nb bits of d, MSB first.
  function automatic logic [9:0] crc10_bits(input logic [9:0] c, input logic [7:0] d,
                                            input int nb);
    logic [9:0] r;
    logic       fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (i < nb) begin
        fb = r[9] ^ d[7-i];
        r  = {r[8:0], 1'b0} ^ (fb ? C10_POLY : 10'h000);
      end
    end
    return r;
  endfunction

  // Advance the 32-bit check by one byte, MSB first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0} ^ (fb ? C32_POLY : 32'h0);
    end
    return r;
  endfunction

endpackage

// File: rtl/cell_tracker.sv
module cell_tracker #(
  parameter int CELL_BYTES = 48,
  parameter int POS_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_soc,
  input  logic             in_last,
  input  logic             in_c10,
  output logic [POS_W-1:0] pos,
  output logic             last_now,
  output logic             c10_now,
  output logic             pkt_new,
  output logic             cell_end
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES - 1);

  logic [POS_W-1:0] pos_q;
  logic             last_q, c10_q, fresh_q;

  assign pos      = in_soc ? '0 : pos_q;
  assign last_now = in_soc ? in_last : last_q;
  assign c10_now  = in_soc ? in_c10 : c10_q;
  assign pkt_new  = in_soc & fresh_q;
  assign cell_end = in_valid & (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      last_q  <= 1'b0;
      c10_q   <= 1'b0;
      fresh_q <= 1'b1;
    end else if (in_valid) begin
      pos_q <= cell_end ? '0 : pos + 1'b1;
      if (in_soc) begin
        last_q  <= in_last;
        c10_q   <= in_c10;
        fresh_q <= 1'b0;
      end
      if (cell_end && last_now) fresh_q <= 1'b1;
    end
  end
endmodule

// File: rtl/crc10_unit.sv
module crc10_unit import atm_crc_pkg::*; #(
  parameter int CELL_BYTES = 48,
  parameter int POS_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_mode,
  input  logic             in_valid,
  input  logic             in_soc,
  input  logic [7:0]       in_data,
  input  logic [POS_W-1:0] pos,
  input  logic             active,
  output logic [7:0]       line_data,
  output logic             mismatch
);
  localparam logic [POS_W-1:0] HI_POS = POS_W'(CELL_BYTES - 2);
  localparam logic [POS_W-1:0] LO_POS = POS_W'(CELL_BYTES - 1);

  logic [9:0] crc_q, fin_q, base, full_step, part_step;
  logic [1:0] rx_hi_q;
  logic       at_hi, at_lo;

  assign at_hi     = pos == HI_POS;
  assign at_lo     = pos == LO_POS;
  assign base      = in_soc ? 10'h000 : crc_q;
  assign full_step = crc10_bits(base, in_data, 8);
  assign part_step = crc10_bits(base, in_data, 6);

  always_comb begin
    line_data = in_data;
    if (tx_mode && active && at_hi) line_data = {in_data[7:2], part_step[9:8]};
    if (tx_mode && active && at_lo) line_data = fin_q[7:0];
  end

  assign mismatch = in_valid & ~tx_mode & active & at_lo & ({rx_hi_q, in_data} != fin_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q   <= '0;
      fin_q   <= '0;
      rx_hi_q <= '0;
    end else if (in_valid) begin
      crc_q <= full_step;
      if (at_hi) begin
        fin_q   <= part_step;
        rx_hi_q <= in_data[1:0];
      end
    end
  end
endmodule

// File: rtl/crc32_unit.sv
module crc32_unit import atm_crc_pkg::*; #(
  parameter int CELL_BYTES = 48,
  parameter int POS_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_mode,
  input  logic             in_valid,
  input  logic             pkt_new,
  input  logic             last_now,
  input  logic [7:0]       line_in,
  input  logic [POS_W-1:0] pos,
  output logic [7:0]       line_data,
  output logic             mismatch
);
  localparam logic [POS_W-1:0] F0 = POS_W'(CELL_BYTES - 4);
  localparam logic [POS_W-1:0] F3 = POS_W'(CELL_BYTES - 1);

  logic [31:0] crc_q, fin_q, base, rx_q;
  logic        in_field;

  assign base     = pkt_new ? 32'hFFFF_FFFF : crc_q;
  assign in_field = last_now & (pos >= F0);

  always_comb begin
    line_data = line_in;
    if (tx_mode && in_field) begin
      case (pos - F0)
        POS_W'(0): line_data = ~base[31:24];
        POS_W'(1): line_data = fin_q[23:16];
        POS_W'(2): line_data = fin_q[15:8];
        default:   line_data = fin_q[7:0];
      endcase
    end
  end

  assign mismatch = in_valid & ~tx_mode & last_now & (pos == F3) &
                    ({rx_q[23:0], line_in} != fin_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= '1;
      fin_q <= '0;
      rx_q  <= '0;
    end else if (in_valid) begin
      if (!in_field) crc_q <= crc32_byte(base, line_in);
      if (in_field) rx_q <= {rx_q[23:0], line_in};
      if (last_now && pos == F0) fin_q <= ~base;
    end
  end
endmodule

// File: rtl/atm_crc_engine.sv
module atm_crc_engine #(
  parameter int CELL_BYTES = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_mode,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_soc,
  input  logic       in_last,
  input  logic       in_c10,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_soc,
  output logic       out_eoc,
  output logic       out_eop,
  output logic       c10_err,
  output logic       c32_err
);
  localparam int POS_W = $clog2(CELL_BYTES + 1);

  logic [POS_W-1:0] byte_pos;
  logic             cell_is_last, c10_sel, pkt_first, cell_done, c10_active;
  logic [7:0]       c10_line, c32_line;
  logic             c10_bad, c32_bad;

  cell_tracker #(.CELL_BYTES(CELL_BYTES), .POS_W(POS_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
    .in_last(in_last), .in_c10(in_c10), .pos(byte_pos), .last_now(cell_is_last),
    .c10_now(c10_sel), .pkt_new(pkt_first), .cell_end(cell_done)
  );

  assign c10_active = c10_sel & ~cell_is_last;

  crc10_unit #(.CELL_BYTES(CELL_BYTES), .POS_W(POS_W)) u_c10 (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .in_valid(in_valid),
    .in_soc(in_soc), .in_data(in_data), .pos(byte_pos), .active(c10_active),
    .line_data(c10_line), .mismatch(c10_bad)
  );

  crc32_unit #(.CELL_BYTES(CELL_BYTES), .POS_W(POS_W)) u_c32 (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .in_valid(in_valid),
    .pkt_new(pkt_first), .last_now(cell_is_last), .line_in(c10_line),
    .pos(byte_pos), .line_data(c32_line), .mismatch(c32_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_soc   <= 1'b0;
      out_eoc   <= 1'b0;
      out_eop   <= 1'b0;
      c10_err   <= 1'b0;
      c32_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_data  <= in_valid ? c32_line : out_data;
      out_soc   <= in_valid & in_soc;
      out_eoc   <= cell_done;
      out_eop   <= cell_done & cell_is_last;
      c10_err   <= c10_bad;
      c32_err   <= c32_bad;
    end
  end
endmodule

// File: rtl/atm_crc_engine_chk.sv
module atm_crc_engine_chk #(
  parameter int CELL_BYTES = 48,
  parameter int POS_W      = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_mode,
  input logic             in_valid,
  input logic [7:0]       in_data,
  input logic [POS_W-1:0] byte_pos,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_eoc,
  input logic             out_eop,
  input logic             c10_err,
  input logic             c32_err
);
  localparam logic [POS_W-1:0] FIELD_START = POS_W'(CELL_BYTES - 4);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_HEAD_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && byte_pos < FIELD_START) |=> (out_data == $past(in_data))); // R2
  AST_EOP_WITH_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_eoc); // R2
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_eoc)); // R11
  AST_C10_ERR_AT_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    c10_err |-> out_eoc); // R5
  AST_C32_ERR_AT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    c32_err |-> out_eop); // R7
  AST_RX_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mode && in_valid) |=> (out_data == $past(in_data))); // R10
  AST_TX_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && in_valid) |=> (!c10_err && !c32_err)); // R10
endmodule

bind atm_crc_engine atm_crc_engine_chk #(.CELL_BYTES(CELL_BYTES), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .in_valid(in_valid), .in_data(in_data),
  .byte_pos(byte_pos), .out_valid(out_valid), .out_data(out_data), .out_eoc(out_eoc),
  .out_eop(out_eop), .c10_err(c10_err), .c32_err(c32_err)
);

// File: tb/atm_crc_engine_bench.sv
module atm_crc_engine_bench;
  localparam int NB = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       tx_mode = 1'b0, in_valid = 1'b0, in_soc = 1'b0, in_last = 1'b0, in_c10 = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid, out_soc, out_eoc, out_eop, c10_err, c32_err;
  logic [7:0] out_data;

  atm_crc_engine u_atm_crc_engine (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .in_valid(in_valid), .in_data(in_data),
    .in_soc(in_soc), .in_last(in_last), .in_c10(in_c10), .out_valid(out_valid),
    .out_data(out_data), .out_soc(out_soc), .out_eoc(out_eoc), .out_eop(out_eop),
    .c10_err(c10_err), .c32_err(c32_err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] raw  [0:3][0:NB-1];
  logic [7:0] line [0:3][0:NB-1];
  logic [7:0] sent [0:3][0:NB-1];
  logic [7:0] obuf [0:3][0:NB-1];
  bit e10 [0:3];
  bit e32 [0:3];
  bit eopf[0:3];
  int ocell = 0, opos = 0, ovcnt = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (out_soc) opos = 0;
      if (ocell < 4 && opos < NB) begin
        obuf[ocell][opos] = out_data;
        if (c10_err) e10[ocell] = 1;
        if (c32_err) e32[ocell] = 1;
        if (out_eop) eopf[ocell] = 1;
      end
      opos++;
      ovcnt++;
      if (out_eoc) ocell++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Augmented long division: remainder of whole cell with last 10 bits forced zero.
  function automatic logic [9:0] ref_c10(input int c, input bit use_out);
    logic [9:0] r;
    bit b, top;
    r = '0;
    for (int k = 0; k < NB*8; k++) begin
      if (use_out) b = obuf[c][k/8][7-(k%8)];
      else         b = (k < NB*8-10) ? line[c][k/8][7-(k%8)] : 1'b0;
      top = r[9];
      r   = {r[8:0], b};
      if (top) r = r ^ 10'h233;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_c32(input int s, input int e);
    logic [31:0] r;
    bit top;
    r = 32'hFFFF_FFFF;
    for (int c = s; c <= e; c++)
      for (int i = 0; i < ((c == e) ? NB-4 : NB); i++)
        for (int k = 7; k >= 0; k--) begin
          top = r[31] ^ line[c][i][k];
          r   = r << 1;
          if (top) r = r ^ 32'h04C11DB7;
        end
    return ~r;
  endfunction

  task automatic build(input int n, input logic [3:0] lastm, input logic [3:0] c10m, input int seed);
    int ps;
    logic [9:0]  x;
    logic [31:0] y;
    ps = 0;
    for (int c = 0; c < n; c++)
      for (int i = 0; i < NB; i++) begin
        raw[c][i]  = 8'(seed*37 + c*91 + i*13 + (i >> 2)) ^ 8'(i*i);
        line[c][i] = raw[c][i];
      end
    for (int c = 0; c < n; c++) begin
      if (!lastm[c] && c10m[c]) begin
        x = ref_c10(c, 0);
        line[c][NB-2] = {line[c][NB-2][7:2], x[9:8]};
        line[c][NB-1] = x[7:0];
      end
      if (lastm[c]) begin
        y = ref_c32(ps, c);
        line[c][NB-4] = y[31:24];
        line[c][NB-3] = y[23:16];
        line[c][NB-2] = y[15:8];
        line[c][NB-1] = y[7:0];
        ps = c + 1;
      end
    end
  endtask

  task automatic run(input string name, input int n, input logic [3:0] lastm, input logic [3:0] c10m,
                     input bit tx, input bit gap, input int bc, input int bb, input int seed);
    bit    pkt_bad, x10, x32;
    string tag;
    build(n, lastm, c10m, seed);
    for (int c = 0; c < 4; c++) begin e10[c] = 0; e32[c] = 0; eopf[c] = 0; end
    ocell = 0; opos = 0; ovcnt = 0;
    @(negedge clk);
    tx_mode = tx;
    for (int c = 0; c < n; c++)
      for (int i = 0; i < NB; i++) begin
        sent[c][i] = tx ? raw[c][i] : line[c][i];
        if (!tx && c == bc && i == bb) sent[c][i] = sent[c][i] ^ 8'h10;
        @(negedge clk);
        in_valid = 1; in_data = sent[c][i]; in_soc = (i == 0);
        in_last = lastm[c]; in_c10 = c10m[c];
        if (gap && (i % 5 == 2)) begin
          @(negedge clk);
          in_valid = 0; in_soc = 0; in_data = 8'hA5;
        end
      end
    @(negedge clk);
    in_valid = 0; in_soc = 0;
    @(negedge clk);
    @(negedge clk);
    chk(ovcnt == n*NB, "R11", {name, " output byte count"}, ovcnt, n*NB);
    chk(ocell == n, "R2", {name, " cells delivered"}, ocell, n);
    pkt_bad = 0;
    for (int c = 0; c < n; c++) begin
      chk(eopf[c] == lastm[c], "R2", {name, " end-of-packet marker"}, eopf[c], lastm[c]);
      for (int i = 0; i < NB; i++) begin
        if (!tx)                    tag = "R10";
        else if (i < NB-4)          tag = "R2";
        else if (lastm[c])          tag = c10m[c] ? "R9" : "R6";
        else if (!c10m[c])          tag = "R4";
        else if (i >= NB-2)         tag = "R3";
        else                        tag = "R2";
        chk(obuf[c][i] == (tx ? line[c][i] : sent[c][i]), tag,
            $sformatf("%s cell %0d byte %0d", name, c, i), obuf[c][i], tx ? line[c][i] : sent[c][i]);
      end
      if (tx && !lastm[c] && c10m[c])
        chk(ref_c10(c, 1) == 10'h0, "R3", {name, " inserted cell divides evenly"}, ref_c10(c, 1), 0);
      if (c == bc) pkt_bad = 1;
      x10 = !tx && c10m[c] && !lastm[c] && (c == bc);
      x32 = !tx && lastm[c] && pkt_bad;
      chk(e10[c] == x10, tx ? "R10" : ((lastm[c] && c10m[c]) ? "R9" : "R5"),
          $sformatf("%s cell %0d c10_err", name, c), e10[c], x10);
      chk(e32[c] == x32, tx ? "R10" : "R7", $sformatf("%s cell %0d c32_err", name, c), e32[c], x32);
      if (lastm[c]) pkt_bad = 0;
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({out_valid, out_soc, out_eoc, out_eop, c10_err, c32_err} == 6'b0, "R1", "outputs after reset",
        {out_valid, out_soc, out_eoc, out_eop, c10_err, c32_err}, 0);
  endtask

  task automatic t_two_packets_tx();
    logic [31:0] y;
    run("tx two packets", 3, 4'b0110, 4'b0011, 1, 0, -1, 0, 4);
    y = ref_c32(2, 2);
    chk({obuf[2][NB-4], obuf[2][NB-3], obuf[2][NB-2], obuf[2][NB-1]} == y, "R8",
        "second packet restarts its check", {obuf[2][NB-4], obuf[2][NB-3], obuf[2][NB-2], obuf[2][NB-1]}, y);
  endtask

  initial begin
    t_reset();
    run("tx single", 1, 4'b0001, 4'b0001, 1, 0, -1, 0, 1);
    run("tx multi", 3, 4'b0100, 4'b0101, 1, 0, -1, 0, 2);
    run("tx gaps", 2, 4'b0010, 4'b0001, 1, 1, -1, 0, 3);
    t_two_packets_tx();
    run("rx clean", 3, 4'b0100, 4'b0011, 0, 0, -1, 0, 5);
    run("rx c10 bad", 3, 4'b0100, 4'b0011, 0, 0, 0, 10, 6);
    run("rx c32 field bad", 2, 4'b0010, 4'b0001, 0, 0, 1, 45, 7);
    run("rx last c10", 1, 4'b0001, 4'b0001, 0, 0, -1, 0, 8);
    run("rx two packets gaps R8", 3, 4'b0101, 4'b0010, 0, 1, 2, 3, 9);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule